// File: doc/BRIEF.md
# Tick Counter with Compare Limit

This block keeps a free-running tick count and raises a single timer event when that count reaches a limit that software has programmed. One copy serves the processor tick. Further copies serve the system tick and the hypervisor system tick. The count advances by one on each strobe of `tick_en`, which arrives at the configured tick rate. Software can load the count, read it, and program the compare limit through a small write and read interface.

The top bit of every written word is not stored as data. Writing the count or writing the limit copies that bit into one disable flag, and a read shows the flag in the top bit of the count. While the flag is set, the counter keeps running but no event reaches `match_o`. Each limit write arms one compare. The compare is consumed the first time a strobe brings the count to or past the limit. The event is a one-cycle pulse that the software interrupt register is expected to latch.

Top module: `tick_timer`

## Requirements
- R1: Each cycle with `tick_en` high and no count load adds one to the 63-bit count, whether or not the disable flag is set. Without a strobe, the count holds.
- R2: A count write (`cnt_wr`) loads `wr_data[62:0]` into the count and `wr_data[63]` into the disable flag. A count write wins over a strobe in the same cycle.
- R3: `rd_data[62:0]` is the current count. `rd_data[63]` is 1 when the disable flag is set and 0 when it is clear.
- R4: A limit write (`lim_wr`) stores `wr_data[62:0]` as the limit and copies `wr_data[63]` into the same disable flag. It arms the compare only when the stored limit is nonzero and `wr_data[63]` is 0. If a limit write and a count write occur in the same cycle, the limit write takes effect and the count load is dropped.
- R5: A limit of zero never arms the compare, so no pulse follows until a nonzero limit is written.
- R6: When a strobe arrives while the compare is armed, and the incremented count is greater than or equal to the limit, the compare is consumed. If the flag is clear, `match_o` is high for exactly the one cycle after that clock edge. A strobe in a cycle that also carries a write is not compared.
- R7: A limit that is already below the count fires on the next strobe rather than being missed.
- R8: A compare that is consumed while the disable flag is set produces no pulse. Clearing the flag afterwards does not bring that event back.
- R9: Reset (synchronous, active low) sets the disable flag, clears the count and the limit, cancels any armed compare, and holds `match_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Increment strobe at the tick rate |
| cnt_wr | input | 1 | Write `wr_data` to the count |
| lim_wr | input | 1 | Write `wr_data` to the limit |
| wr_data | input | 64 | Write word; bit 63 is the disable flag |
| rd_data | output | 64 | Count, with bit 63 showing the disable flag |
| match_o | output | 1 | One-cycle timer-match pulse |

## Verification
Two faults are visible at once. A wrong count or a wrong disable flag shows on `rd_data` in the first cycle after the edge that corrupted it. A stuck disable flag shows because the top bit no longer follows the last write. An arm bit or a limit register holding the wrong value gives no sign until a later strobe: the fault then appears as a missing pulse, an extra pulse, or a repeated pulse at the strobe where the count meets the limit. For that reason the bench runs sequences that cross the limit after re-enabling, after writing a zero limit, and after a reset.

// File: rtl/tick_timer_pkg.sv
// Package: shared types for the tick timer.
// Assumes: at most one write operation takes effect per cycle. The top
// module decodes its write strobes into this encoding.
package tick_timer_pkg;

    // Which register the write port updates in the current cycle.
    typedef enum logic [1:0] {
        WOP_NONE  = 2'd0,
        WOP_COUNT = 2'd1,
        WOP_LIMIT = 2'd2
    } wr_op_e;

    // Value the disable flag takes on reset.
    localparam logic DIS_AT_RESET = 1'b1;

endpackage

// File: rtl/tick_counter.sv
// Module: tick_counter
// Holds the running count and the shared disable flag. The count advances
// on every strobe whether or not the flag is set. A count write loads the
// count. Either a count write or a limit write updates the flag.
// Assumes: op is already decoded, and a limit write outranks a count write.
module tick_counter
    import tick_timer_pkg::*;
#(
    parameter int unsigned VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  wr_op_e           op,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             wr_dis,
    output logic [VAL_W-1:0] cnt_q,
    output logic             dis_q
);

    // Count register: a write loads it, otherwise a strobe advances it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (op == WOP_COUNT)
            cnt_q <= wr_val;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    // Disable flag: follows the top bit of either kind of write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_q <= DIS_AT_RESET;
        else if (op != WOP_NONE)
            dis_q <= wr_dis;
    end

    AST_RESET_COUNT: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && dis_q)); // R9
    AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && op != WOP_COUNT) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && op != WOP_COUNT) |=> $stable(cnt_q)); // R1
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_COUNT) |=> (cnt_q == $past(wr_val) && dis_q == $past(wr_dis))); // R2

endmodule

// File: rtl/tick_compare.sv
// Module: tick_compare
// Holds the limit and a one-shot arm bit. The first strobe that brings the
// count to or past the limit consumes the arm, and a pulse follows only if
// the flag is clear.
// Assumes: cnt_q and dis_q come from tick_counter in the same clock domain.
module tick_compare
    import tick_timer_pkg::*;
#(
    parameter int unsigned VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  wr_op_e           op,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             wr_dis,
    input  logic [VAL_W-1:0] cnt_q,
    input  logic             dis_q,
    output logic             match_o
);

    logic [VAL_W-1:0] lim_q;
    logic             arm_q;
    logic [VAL_W-1:0] cnt_nxt;
    logic             hit;

    // Compare the count after this strobe against the limit.
    always_comb begin
        cnt_nxt = cnt_q + 1'b1;
        hit     = tick_en && (op == WOP_NONE) && arm_q && (cnt_nxt >= lim_q);
    end

    // Limit register: only a limit write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= '0;
        else if (op == WOP_LIMIT)
            lim_q <= wr_val;
    end

    // Arm bit: set by an enabled nonzero limit write, cleared by a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (op == WOP_LIMIT)
            arm_q <= (|wr_val) && !wr_dis;
        else if (hit)
            arm_q <= 1'b0;
    end

    // Match pulse: registered hit, masked by the disable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_o <= 1'b0;
        else
            match_o <= hit && !dis_q;
    end

    AST_RESET_DISARM: assert property (@(posedge clk)
        !rst_n |=> (!arm_q && !match_o)); // R9
    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_LIMIT && wr_val == '0) |=> !arm_q); // R5
    AST_DIS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_LIMIT && wr_dis) |=> !arm_q); // R4
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o); // R6
    AST_NO_MATCH_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> !$past(dis_q)); // R8

endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer (top)
// Tick counter with compare limit. The top bit of the write word and of
// the read word is the shared disable flag.
// Assumes: CNT_W >= 2, and software does not rely on which write wins when
// both strobes are high (the limit write does).
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_wr,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             match_o
);

    localparam int unsigned VAL_W = CNT_W - 1;

    wr_op_e           op;
    logic [VAL_W-1:0] cnt_q;
    logic             dis_q;

    // Decode the write strobes; the limit write takes precedence.
    always_comb begin
        if (lim_wr)
            op = WOP_LIMIT;
        else if (cnt_wr)
            op = WOP_COUNT;
        else
            op = WOP_NONE;
    end

    tick_counter #(.VAL_W(VAL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .op      (op),
        .wr_val  (wr_data[VAL_W-1:0]),
        .wr_dis  (wr_data[CNT_W-1]),
        .cnt_q   (cnt_q),
        .dis_q   (dis_q)
    );

    tick_compare #(.VAL_W(VAL_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .op      (op),
        .wr_val  (wr_data[VAL_W-1:0]),
        .wr_dis  (wr_data[CNT_W-1]),
        .cnt_q   (cnt_q),
        .dis_q   (dis_q),
        .match_o (match_o)
    );

    // Read view: the flag occupies the top bit.
    always_comb rd_data = {dis_q, cnt_q};

    AST_LIMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && cnt_wr) |=> rd_data[CNT_W-1] == $past(wr_data[CNT_W-1])); // R4

endmodule

// File: tb/tick_timer_tb.sv
// Scoreboard bench: the driver task updates a reference model and pushes
// the expected port values; the monitor pops them at the falling edge.
module tick_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 64;
    localparam logic [W-1:0] DIS = 64'h8000_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         cnt_wr = 1'b0;
    logic         lim_wr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         match_o;

    typedef struct {
        logic [W-1:0] rd;
        logic         mt;
        string        req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    logic [W-2:0] m_cnt = '0;
    logic [W-2:0] m_lim = '0;
    logic         m_dis = 1'b1;
    logic         m_arm = 1'b0;
    logic         m_mt  = 1'b0;

    tick_timer #(.CNT_W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_wr  (cnt_wr),
        .lim_wr  (lim_wr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .match_o (match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic step(input logic r, input logic t, input logic cw,
                        input logic lw, input logic [W-1:0] d, input string req);
        exp_t e;
        @(negedge clk);
        rst_n = r; tick_en = t; cnt_wr = cw; lim_wr = lw; wr_data = d;
        @(posedge clk);
        if (!r) begin
            m_cnt = '0; m_dis = 1'b1; m_lim = '0; m_arm = 1'b0; m_mt = 1'b0;
        end else begin
            m_mt = 1'b0;
            if (t && !lw && !cw && m_arm && (m_cnt + 1'b1) >= m_lim) begin
                m_arm = 1'b0;
                m_mt  = !m_dis;
            end
            if (cw && !lw)  m_cnt = d[W-2:0];
            else if (t)     m_cnt = m_cnt + 1'b1;
            if (lw) begin
                m_lim = d[W-2:0];
                m_arm = (d[W-2:0] != '0) && !d[W-1];
                m_dis = d[W-1];
            end else if (cw) begin
                m_dis = d[W-1];
            end
        end
        e.rd = {m_dis, m_cnt}; e.mt = m_mt; e.req = req;
        q.push_back(e);
    endtask

    task automatic tk(input string req);               step(1, 1, 0, 0, '0, req); endtask
    task automatic idle(input string req);             step(1, 0, 0, 0, '0, req); endtask
    task automatic wcnt(input logic [W-1:0] d, input string req); step(1, 0, 1, 0, d, req); endtask
    task automatic wlim(input logic [W-1:0] d, input string req); step(1, 0, 0, 1, d, req); endtask

    // Monitor: compare the outputs after each edge with the expected item.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (rd_data !== e.rd || match_o !== e.mt) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h match=%b expected rd_data=%h match=%b",
                         e.req, rd_data, match_o, e.rd, e.mt);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: rd_data=%h match=%b expected run to end", rd_data, match_o);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(0, 0, 0, 0, '0, "R9");                   // reset state
        step(0, 1, 0, 0, '0, "R9");
        for (int i = 0; i < 3; i++) tk("R1");          // counts while disabled
        idle("R3");
        wcnt(64'd100, "R2");                           // enable, load
        idle("R3");
        wlim(64'd105, "R4");
        for (int i = 0; i < 7; i++) tk("R6");          // pulse when count hits 105
        wlim(64'd0, "R5");
        for (int i = 0; i < 4; i++) tk("R5");          // zero limit: no pulse
        wlim(64'd50, "R7");                            // limit in the past
        tk("R7");
        tk("R7");
        wlim(64'd200, "R8");
        wcnt(DIS | 64'd195, "R8");                     // disable, stay armed
        for (int i = 0; i < 7; i++) tk("R8");          // crosses 200 silently
        wcnt(64'd210, "R8");                           // re-enable
        tk("R8");
        tk("R8");
        wlim(DIS | 64'd300, "R4");                     // limit write disables
        idle("R3");
        step(1, 1, 1, 0, 64'd500, "R2");               // load beats strobe
        step(1, 0, 1, 1, 64'd700, "R4");               // limit beats count
        wlim(64'd503, "R6");
        for (int i = 0; i < 4; i++) tk("R6");
        wlim(64'd520, "R9");
        step(0, 0, 0, 0, '0, "R9");                    // reset cancels compare
        wcnt(64'd515, "R9");
        for (int i = 0; i < 7; i++) tk("R9");
        idle("R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule